// File: doc/BRIEF.md
# Sector Hamming ECC Engine

This block protects NAND flash pages sector by sector. As a byte stream passes between the controller and the flash, it folds each byte into a Hamming parity accumulator that spans one 512-byte sector. The resulting 24-bit code can correct one flipped bit and detect two. A page holds one to four sectors. When writing, the controller takes the finished code of each sector from `code_out` and stores the codes in the spare area after the page data. When reading, the controller streams the page data and then the stored code bytes through the block. The block then reports, for each sector, one of three results: the sector is clean, it has a single-bit error at a given byte and bit, or it is uncorrectable.

A transfer starts only when a valid byte arrives at a sector-aligned offset while the engine is idle or done. Bytes with an unaligned offset in those states are ignored. The block has five states:

- IDLE: after reset. It goes to DATA on an aligned start.
- DATA: sector accumulation. A write goes to DONE and a read goes to CODE when the closing sector completes. The closing sector is the one that completes with the last flag set, or the fourth one.
- CODE: collects the stored code bytes. It goes to CHECK after the last code byte.
- CHECK: one cycle of syndrome evaluation. It goes to DONE.
- DONE: results are held. It goes back to DATA on an aligned start.

Top module: `sector_ecc`

## Requirements
- R1: A sector's code is 24 bits wide. For k in 0..8, bit k is the XOR of every data bit in bytes whose index within the sector has bit k set, and bit 9+k covers bytes whose index has bit k clear. For k in 0..2, bit 18+k is the XOR of every data bit whose bit number has bit k set, and bit 21+k covers bit numbers with bit k clear. Code byte j is code bits [8j+7:8j].
- R2: A transfer starts only on a valid byte whose `in_addr_lo` is zero while the engine is idle or done. In those states, a valid byte with a nonzero offset changes no output and no state.
- R3: Completed sectors fill code slots 0, 1, 2 and 3 in order, with slot s at `code_out[24s+23:24s]`. `sect_cnt` gives the number of completed sectors. Unused slots read zero.
- R4: `in_last` closes the page only when it comes with the 512th byte of a sector and is ignored on any other byte. The page also closes by itself when the fourth sector completes.
- R5: After a write, `done` is high from the cycle after the closing byte, and every status is 0.
- R6: After a read closes, the block takes 3 code bytes per sector, sector 0 first and byte 0 first within each sector. `done` rises two cycles after the last code byte.
- R7: A sector whose stored code equals its recomputed code reports status 0 (clean) at `stat_out[2s+1:2s]`.
- R8: Let the syndrome be the stored code XOR the recomputed code. If, for every k, syndrome bits k and 9+k differ and syndrome bits 18+k and 21+k differ, the status is 1 (single-bit error). In that case `err_byte_out` reports syndrome bits [8:0] and `err_bit_out` reports syndrome bits [20:18].
- R9: Any other nonzero syndrome gives status 2 (uncorrectable), and the sector's positions read zero. Status 3 never occurs.
- R10: Codes, statuses, positions and `done` hold until the next aligned start. The cycle after that start, `done`, `sect_cnt`, the statuses and the code slots are all zero.
- R11: After reset, `done`, `sect_cnt` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_data | input | 8 | Data or code byte |
| in_addr_lo | input | 9 | Byte offset of the access within its sector |
| in_read | input | 1 | Direction of the transfer, sampled at start (1 = read) |
| in_last | input | 1 | The final data access of the page |
| done | output | 1 | Results valid |
| sect_cnt | output | 3 | Completed sectors in this transfer |
| code_out | output | 96 | Recomputed code per sector slot |
| stat_out | output | 8 | 2-bit status per slot |
| err_byte_out | output | 36 | 9-bit error byte per slot |
| err_bit_out | output | 12 | 3-bit error bit per slot |

## Verification
The bound checker checks the following on every cycle:

- unaligned bytes leave an idle engine idle;
- held results stay stable while done;
- writes never report a nonzero status;
- status 3 never appears;
- positions are zero unless the status is 1;
- slots beyond the sector count stay clear;
- a read reaches done only through the check state.

Only the bench scenarios show the exact code bits, the decoded byte and bit positions, and the split between single and double faults. These scenarios cover corners such as byte 0 bit 0 and byte 511 bit 7, faults in the stored code bytes, last flags that come early, and pages that close by filling up.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_DATA  = 3'd1,
        S_CODE  = 3'd2,
        S_CHECK = 3'd3,
        S_DONE  = 3'd4
    } ecc_state_e;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'd0,
        ST_FIXABLE = 2'd1,
        ST_FATAL   = 2'd2
    } ecc_status_e;

    localparam int BIT_IDX_W = 3;

endpackage

// File: rtl/ecc_sector_acc.sv
module ecc_sector_acc #(
    parameter int IDX_W  = 9,
    parameter int CODE_W = 2 * IDX_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic [7:0]        data,
    output logic [CODE_W-1:0] code_fin,
    output logic              at_end
);
    logic [IDX_W-1:0] lp_hi_q, lp_lo_q, idx_q;
    logic [7:0]       col_q;
    logic [IDX_W-1:0] lp_hi_n, lp_lo_n, idx_cur;
    logic [7:0]       col_n;
    logic [2:0]       cp_hi, cp_lo;
    logic             bpar;

    always_comb begin
        idx_cur = restart ? '0 : idx_q;
        bpar    = ^data;
        for (int k = 0; k < IDX_W; k++) begin
            lp_hi_n[k] = (restart ? 1'b0 : lp_hi_q[k]) ^ (bpar & idx_cur[k]);
            lp_lo_n[k] = (restart ? 1'b0 : lp_lo_q[k]) ^ (bpar & ~idx_cur[k]);
        end
        col_n = (restart ? 8'h00 : col_q) ^ data;
        for (int k = 0; k < 3; k++) begin
            cp_hi[k] = 1'b0;
            cp_lo[k] = 1'b0;
            for (int b = 0; b < 8; b++) begin
                if (((b >> k) & 1) == 1) cp_hi[k] = cp_hi[k] ^ col_n[b];
                else                      cp_lo[k] = cp_lo[k] ^ col_n[b];
            end
        end
        code_fin = {cp_lo, cp_hi, lp_lo_n, lp_hi_n};
        at_end   = (idx_cur == '1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_hi_q <= '0;
            lp_lo_q <= '0;
            col_q   <= '0;
            idx_q   <= '0;
        end else if (en) begin
            if (at_end) begin
                lp_hi_q <= '0;
                lp_lo_q <= '0;
                col_q   <= '0;
                idx_q   <= '0;
            end else begin
                lp_hi_q <= lp_hi_n;
                lp_lo_q <= lp_lo_n;
                col_q   <= col_n;
                idx_q   <= idx_cur + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome #(
    parameter int IDX_W  = 9,
    parameter int CODE_W = 2 * IDX_W + 6
) (
    input  logic [CODE_W-1:0] calc,
    input  logic [CODE_W-1:0] stored,
    output logic [1:0]        status,
    output logic [IDX_W-1:0]  byte_pos,
    output logic [2:0]        bit_pos
);
    import ecc_pkg::*;
    logic [CODE_W-1:0] syn;
    logic [IDX_W-1:0]  line_pair;
    logic [2:0]        col_pair;

    always_comb begin
        syn       = calc ^ stored;
        line_pair = syn[IDX_W-1:0] ^ syn[2*IDX_W-1:IDX_W];
        col_pair  = syn[2*IDX_W+2:2*IDX_W] ^ syn[2*IDX_W+5:2*IDX_W+3];
        byte_pos  = '0;
        bit_pos   = '0;
        if (syn == '0) begin
            status = ST_CLEAN;
        end else if ((&line_pair) && (&col_pair)) begin
            status   = ST_FIXABLE;
            byte_pos = syn[IDX_W-1:0];
            bit_pos  = syn[2*IDX_W+2:2*IDX_W];
        end else begin
            status = ST_FATAL;
        end
    end
endmodule

// File: rtl/sector_ecc.sv
module sector_ecc #(
    parameter int SECT_BYTES = 512,
    parameter int MAX_SECT   = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  logic [7:0]                           in_data,
    input  logic [$clog2(SECT_BYTES)-1:0]        in_addr_lo,
    input  logic                                 in_read,
    input  logic                                 in_last,
    output logic                                 done,
    output logic [$clog2(MAX_SECT+1)-1:0]        sect_cnt,
    output logic [MAX_SECT*(2*$clog2(SECT_BYTES)+6)-1:0] code_out,
    output logic [MAX_SECT*2-1:0]                stat_out,
    output logic [MAX_SECT*$clog2(SECT_BYTES)-1:0] err_byte_out,
    output logic [MAX_SECT*3-1:0]                err_bit_out
);
    import ecc_pkg::*;

    localparam int IDX_W      = $clog2(SECT_BYTES);
    localparam int CODE_W     = 2 * IDX_W + 6;
    localparam int CODE_BYTES = (CODE_W + 7) / 8;
    localparam int CNT_W      = $clog2(MAX_SECT + 1);
    localparam int SLOT_W     = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1;
    localparam int CB_W       = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(MAX_SECT - 1);
    localparam logic [CB_W-1:0]  LAST_CB   = CB_W'(CODE_BYTES - 1);

    ecc_state_e state, state_nx;
    logic                    dir_rd;
    logic [CNT_W-1:0]        sect_q, cb_sect;
    logic [CB_W-1:0]         cb_byte;
    logic [CODE_W-1:0]       code_q  [MAX_SECT];
    logic [CODE_BYTES*8-1:0] rdc_q   [MAX_SECT];
    logic [1:0]              stat_q  [MAX_SECT];
    logic [IDX_W-1:0]        ebyte_q [MAX_SECT];
    logic [2:0]              ebit_q  [MAX_SECT];
    logic [1:0]              syn_st  [MAX_SECT];
    logic [IDX_W-1:0]        syn_by  [MAX_SECT];
    logic [2:0]              syn_bi  [MAX_SECT];

    logic              start, acc_en, at_end, sect_close, data_end, code_last;
    logic [CODE_W-1:0] code_fin;

    assign start      = in_valid && (in_addr_lo == '0) &&
                        (state == S_IDLE || state == S_DONE);
    assign acc_en     = start || (in_valid && state == S_DATA);
    assign sect_close = in_valid && (state == S_DATA) && at_end;
    assign data_end   = sect_close && (in_last || sect_q == LAST_SLOT);
    assign code_last  = in_valid && (state == S_CODE) && (cb_byte == LAST_CB) &&
                        (cb_sect == sect_q - CNT_W'(1));

    ecc_sector_acc #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(acc_en), .restart(start),
        .data(in_data), .code_fin(code_fin), .at_end(at_end)
    );

    for (genvar s = 0; s < MAX_SECT; s++) begin : g_slot
        ecc_syndrome #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_syn (
            .calc(code_q[s]), .stored(rdc_q[s][CODE_W-1:0]),
            .status(syn_st[s]), .byte_pos(syn_by[s]), .bit_pos(syn_bi[s])
        );
        assign code_out[s*CODE_W +: CODE_W]   = code_q[s];
        assign stat_out[s*2 +: 2]             = stat_q[s];
        assign err_byte_out[s*IDX_W +: IDX_W] = ebyte_q[s];
        assign err_bit_out[s*3 +: 3]          = ebit_q[s];
    end

    assign done     = (state == S_DONE);
    assign sect_cnt = sect_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_DATA;
            S_DATA:  if (data_end) state_nx = dir_rd ? S_CODE : S_DONE;
            S_CODE:  if (code_last) state_nx = S_CHECK;
            S_CHECK: state_nx = S_DONE;
            S_DONE:  if (start) state_nx = S_DATA;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_rd  <= 1'b0;
            sect_q  <= '0;
            cb_sect <= '0;
            cb_byte <= '0;
            for (int s = 0; s < MAX_SECT; s++) begin
                code_q[s]  <= '0;
                rdc_q[s]   <= '0;
                stat_q[s]  <= '0;
                ebyte_q[s] <= '0;
                ebit_q[s]  <= '0;
            end
        end else begin
            if (start) begin
                dir_rd  <= in_read;
                sect_q  <= '0;
                cb_sect <= '0;
                cb_byte <= '0;
                for (int s = 0; s < MAX_SECT; s++) begin
                    code_q[s]  <= '0;
                    rdc_q[s]   <= '0;
                    stat_q[s]  <= '0;
                    ebyte_q[s] <= '0;
                    ebit_q[s]  <= '0;
                end
            end
            if (sect_close) begin
                code_q[sect_q[SLOT_W-1:0]] <= code_fin;
                sect_q <= sect_q + CNT_W'(1);
            end
            if (in_valid && state == S_CODE) begin
                rdc_q[cb_sect[SLOT_W-1:0]][{cb_byte, 3'b000} +: 8] <= in_data;
                if (cb_byte == LAST_CB) begin
                    cb_byte <= '0;
                    cb_sect <= cb_sect + CNT_W'(1);
                end else begin
                    cb_byte <= cb_byte + CB_W'(1);
                end
            end
            if (state == S_CHECK) begin
                for (int s = 0; s < MAX_SECT; s++) begin
                    if (CNT_W'(s) < sect_q) begin
                        stat_q[s]  <= syn_st[s];
                        ebyte_q[s] <= syn_by[s];
                        ebit_q[s]  <= syn_bi[s];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sector_ecc_chk.sv
module sector_ecc_chk #(
    parameter int SECT_BYTES = 512,
    parameter int MAX_SECT   = 4
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   in_valid,
    input logic [$clog2(SECT_BYTES)-1:0]          in_addr_lo,
    input ecc_pkg::ecc_state_e                    state,
    input logic                                   dir_rd,
    input logic                                   done,
    input logic [$clog2(MAX_SECT+1)-1:0]          sect_cnt,
    input logic [MAX_SECT*(2*$clog2(SECT_BYTES)+6)-1:0] code_out,
    input logic [MAX_SECT*2-1:0]                  stat_out,
    input logic [MAX_SECT*$clog2(SECT_BYTES)-1:0] err_byte_out,
    input logic [MAX_SECT*3-1:0]                  err_bit_out
);
    import ecc_pkg::*;
    localparam int IDX_W = $clog2(SECT_BYTES);
    localparam int CNT_W = $clog2(MAX_SECT + 1);

    p_unaligned_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && in_valid && in_addr_lo != '0) |=> (state == S_IDLE && sect_cnt == '0));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sect_cnt <= CNT_W'(MAX_SECT));

    p_write_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dir_rd) |-> (stat_out == '0));

    p_read_via_check_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && dir_rd) |-> ($past(state) == S_CHECK));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(in_valid && in_addr_lo == '0)) |=>
        (done && $stable(stat_out) && $stable(code_out) && $stable(err_byte_out)));

    for (genvar s = 0; s < MAX_SECT; s++) begin : g_chk
        p_no_status3_r9: assert property (@(posedge clk) disable iff (!rst_n)
            stat_out[s*2 +: 2] != 2'd3);
        p_pos_only_fixable_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_out[s*2 +: 2] != 2'd1) |->
            (err_byte_out[s*IDX_W +: IDX_W] == '0 && err_bit_out[s*3 +: 3] == '0));
        p_unused_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (done && CNT_W'(s) >= sect_cnt) |-> (stat_out[s*2 +: 2] == 2'd0));
    end
endmodule

bind sector_ecc sector_ecc_chk #(.SECT_BYTES(SECT_BYTES), .MAX_SECT(MAX_SECT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr_lo(in_addr_lo),
    .state(state), .dir_rd(dir_rd), .done(done), .sect_cnt(sect_cnt),
    .code_out(code_out), .stat_out(stat_out), .err_byte_out(err_byte_out),
    .err_bit_out(err_bit_out)
);

// File: tb/sector_ecc_test.sv
module sector_ecc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic [8:0]  in_addr_lo = 9'd0;
    logic        in_read = 1'b0;
    logic        in_last = 1'b0;
    logic        done;
    logic [2:0]  sect_cnt;
    logic [95:0] code_out;
    logic [7:0]  stat_out;
    logic [35:0] err_byte_out;
    logic [11:0] err_bit_out;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  sd [0:2047];
    logic [23:0] cc [0:3];
    logic [23:0] sc [0:3];
    int ek [0:3];
    int eb [0:3];
    int et [0:3];

    always #5 clk = ~clk;

    sector_ecc uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_addr_lo(in_addr_lo), .in_read(in_read), .in_last(in_last),
        .done(done), .sect_cnt(sect_cnt), .code_out(code_out), .stat_out(stat_out),
        .err_byte_out(err_byte_out), .err_bit_out(err_bit_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] mcode(input int s);
        logic [23:0] c = '0;
        for (int i = 0; i < 512; i++)
            for (int b = 0; b < 8; b++)
                if (sd[s*512+i][b]) begin
                    for (int k = 0; k < 9; k++)
                        if (((i >> k) & 1) == 1) c[k] = ~c[k]; else c[9+k] = ~c[9+k];
                    for (int k = 0; k < 3; k++)
                        if (((b >> k) & 1) == 1) c[18+k] = ~c[18+k]; else c[21+k] = ~c[21+k];
                end
        return c;
    endfunction

    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R6", "done reached", 64'(done), 64'd1);
    endtask

    // kinds: 0 clean, 1 single data flip, 2 double data flip, 3 stored code flip
    task automatic run_txn(input bit rd, input int ns, input bit use_last, input int early);
        for (int i = 0; i < ns * 512; i++) sd[i] = 8'($urandom);
        for (int s = 0; s < ns; s++) cc[s] = mcode(s);
        if (rd) begin
            for (int s = 0; s < ns; s++) begin
                if (ek[s] == 1 || ek[s] == 2)
                    sd[s*512+eb[s]] = sd[s*512+eb[s]] ^ 8'(1 << et[s]);
                if (ek[s] == 2) begin
                    int b2 = (eb[s] + 1 + int'($urandom_range(0, 510))) % 512;
                    sd[s*512+b2] = sd[s*512+b2] ^ 8'(1 << $urandom_range(0, 7));
                end
            end
        end
        for (int s = 0; s < ns; s++) sc[s] = mcode(s);
        for (int s = 0; s < ns; s++) begin
            for (int i = 0; i < 512; i++) begin
                @(negedge clk);
                if (s == 0 && i == 1) begin
                    chk(done == 1'b0 && sect_cnt == 3'd0, "R10", "cleared after start",
                        64'({done, sect_cnt}), 64'd0);
                    chk(stat_out == 8'd0 && code_out == 96'd0, "R10", "results cleared",
                        64'(stat_out), 64'd0);
                end
                in_valid   = 1'b1;
                in_read    = rd;
                in_data    = sd[s*512+i];
                in_addr_lo = 9'(i);
                in_last    = (use_last && s == ns - 1 && i == 511) || (i == early);
            end
        end
        if (rd) begin
            for (int s = 0; s < ns; s++)
                for (int b = 0; b < 3; b++) begin
                    logic [7:0] cb = cc[s][b*8 +: 8];
                    @(negedge clk);
                    if (ek[s] == 3 && b == eb[s] % 3) cb = cb ^ 8'(1 << et[s]);
                    in_valid   = 1'b1;
                    in_data    = cb;
                    in_addr_lo = 9'(b);
                    in_last    = 1'b0;
                end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (!rd) chk(done == 1'b1, "R5", "done one cycle after last byte", 64'(done), 64'd1);
        wait_done();
        chk(sect_cnt == 3'(ns), "R3", "sector count", 64'(sect_cnt), 64'(ns));
        for (int s = 0; s < 4; s++) begin
            logic [23:0] ex = (s < ns) ? sc[s] : 24'd0;
            logic [1:0]  es = 2'd0;
            logic [8:0]  ebx = 9'd0;
            logic [2:0]  etx = 3'd0;
            chk(code_out[s*24 +: 24] == ex, "R1", "sector code", 64'(code_out[s*24 +: 24]), 64'(ex));
            if (rd && s < ns) begin
                if (ek[s] == 1) begin es = 2'd1; ebx = 9'(eb[s]); etx = 3'(et[s]); end
                else if (ek[s] >= 2) es = 2'd2;
            end
            if (!rd) chk(stat_out[s*2 +: 2] == 2'd0, "R5", "write status", 64'(stat_out[s*2 +: 2]), 64'd0);
            else if (es == 2'd0) chk(stat_out[s*2 +: 2] == es, "R7", "clean status", 64'(stat_out[s*2 +: 2]), 64'(es));
            else if (es == 2'd1) chk(stat_out[s*2 +: 2] == es, "R8", "single status", 64'(stat_out[s*2 +: 2]), 64'(es));
            else chk(stat_out[s*2 +: 2] == es, "R9", "uncorrectable status", 64'(stat_out[s*2 +: 2]), 64'(es));
            chk(err_byte_out[s*9 +: 9] == ebx && err_bit_out[s*3 +: 3] == etx, "R8", "error position",
                64'({err_byte_out[s*9 +: 9], err_bit_out[s*3 +: 3]}), 64'({ebx, etx}));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [95:0] hold_code;
        void'($urandom(32'd20240611));
        for (int s = 0; s < 4; s++) begin ek[s] = 0; eb[s] = 0; et[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && sect_cnt == 3'd0 && code_out == 96'd0 && stat_out == 8'd0 &&
            err_byte_out == 36'd0 && err_bit_out == 12'd0, "R11", "reset state", 64'(done), 64'd0);

        // R2: unaligned byte while idle
        in_valid = 1'b1; in_addr_lo = 9'd7; in_data = 8'h5A;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && sect_cnt == 3'd0 && code_out == 96'd0, "R2", "unaligned ignored in idle",
            64'(sect_cnt), 64'd0);

        // R5 single-sector write
        run_txn(1'b0, 1, 1'b1, -1);

        // R2: unaligned byte while done
        hold_code = code_out;
        @(negedge clk);
        in_valid = 1'b1; in_addr_lo = 9'd300; in_data = 8'hFF;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && sect_cnt == 3'd1 && code_out == hold_code, "R2", "unaligned ignored in done",
            64'(sect_cnt), 64'd1);
        chk(code_out == hold_code, "R10", "results held", 64'(code_out[23:0]), 64'(hold_code[23:0]));

        // R4: page fills without a last flag
        run_txn(1'b0, 4, 1'b0, -1);
        // R4: early last flag ignored
        run_txn(1'b0, 2, 1'b1, 100);

        // directed reads: corners of single, double, code flip
        ek[0] = 1; eb[0] = 0;   et[0] = 0;
        ek[1] = 1; eb[1] = 511; et[1] = 7;
        ek[2] = 2; eb[2] = 40;  et[2] = 3;
        ek[3] = 3; eb[3] = 1;   et[3] = 5;
        run_txn(1'b1, 4, 1'b0, -1);
        ek[0] = 0; ek[1] = 0;
        run_txn(1'b1, 2, 1'b1, -1);

        for (int t = 0; t < 12; t++) begin
            bit rd = 1'($urandom_range(0, 1));
            int ns = int'($urandom_range(1, 4));
            for (int s = 0; s < 4; s++) begin
                ek[s] = int'($urandom_range(0, 3));
                eb[s] = int'($urandom_range(0, 511));
                et[s] = int'($urandom_range(0, 7));
            end
            run_txn(rd, ns, (ns == 4) ? 1'($urandom_range(0, 1)) : 1'b1, -1);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule